// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter

This block is a four-stage twisted-ring counter that steps through an eight-state cycle. Each clock, every stage takes the value of the stage before it, and the first stage takes the inverse of the last stage. That gives 2N states for N stages. The other eight of the sixteen four-bit codes form a separate, unwanted loop of their own if nothing intervenes. The block guards against this in the same way a register with both shift and parallel-load modes would. When the first and last stages hold equal values, the register loads a fixed code instead of shifting.

The state is named Q0..Q3 and appears on port `q`, with `q[0]` = Q0 and `q[3]` = Q3. The legal cycle, read as Q0Q1Q2Q3, is 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001, and then back to 0000. The counter has no streaming data, so it has no valid/ready interface. Its pins are a clock, a synchronous active-low reset and the state outputs. Decoding the states into pulses belongs to whatever logic uses the counter.

Top module: `jc_selfcorrect_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `q` becomes 0000 on that edge. This holds whatever the current state is.
- R2: From reset, the state follows the legal cycle 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001 (read Q0Q1Q2Q3), moving one step per clock and repeating every 8 clocks.
- R3: When Q0=0 and Q3=0, the next state is loaded as 1000, that is, Q0=1 and Q1=Q2=Q3=0.
- R4: When Q0=1 and Q3=1, the next state is loaded as 0111, that is, Q0=0 and Q1=Q2=Q3=1.
- R5: When Q0 differs from Q3, the register shifts. The next Q0 is NOT Q3, and each next Qi (i=1..3) equals the present Q(i-1).
- R6: Once the state is a legal-cycle code, every later state is also a legal-cycle code.
- R7: Starting from any of the 16 codes, the state is a legal-cycle code no later than 2 clocks afterwards. The codes 1010 and 0101 need both clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| q | output | 4 | Counter state, q[0]=Q0 ... q[3]=Q3 |

## Verification
Each result appears one clock after its cause. The next state (shift or forced load) is registered on the first rising edge after the state it depends on. Reset likewise takes effect on the edge where `rst_n` is sampled low. The bench changes inputs and samples `q` only on falling edges, so each check reads the value set by exactly one rising edge. To place an arbitrary code in the register, the bench holds reset for one edge and then overwrites the register between edges. It then compares `q` after the first and the second edges that follow.

// File: rtl/jc_pkg.sv
package jc_pkg;

  typedef enum logic [1:0] {
    JC_SHIFT     = 2'd0,
    JC_LOAD_HEAD = 2'd1,
    JC_LOAD_TAIL = 2'd2
  } jc_op_e;

  // True when the code is one run of equal bits followed by the opposite run.
  function automatic logic jc_is_legal(input logic [31:0] v, input int width);
    int edges;
    edges = 0;
    for (int i = 0; i < width - 1; i++)
      if (v[i] != v[i+1]) edges++;
    return (edges <= 1);
  endfunction

endpackage

// File: rtl/jc_boundary_detect.sv
module jc_boundary_detect
  import jc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] state,
  output jc_op_e       op
);
  logic head_bit;
  logic tail_bit;

  assign head_bit = state[0];
  assign tail_bit = state[N-1];

  always_comb begin
    if (!head_bit && !tail_bit)      op = JC_LOAD_HEAD;
    else if (head_bit && tail_bit)   op = JC_LOAD_TAIL;
    else                             op = JC_SHIFT;
  end
endmodule

// File: rtl/jc_stage.sv
module jc_stage
  import jc_pkg::*;
#(
  parameter int IDX = 0
) (
  input  jc_op_e op,
  input  logic   shift_in,
  output logic   d
);
  localparam logic HEAD_VAL = (IDX == 0);
  localparam logic TAIL_VAL = (IDX != 0);

  always_comb begin
    unique case (op)
      JC_LOAD_HEAD: d = HEAD_VAL;
      JC_LOAD_TAIL: d = TAIL_VAL;
      default:      d = shift_in;
    endcase
  end
endmodule

// File: rtl/jc_state_reg.sv
module jc_state_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= d;
  end

  assign q = state_q;
endmodule

// File: rtl/jc_selfcorrect_counter.sv
module jc_selfcorrect_counter
  import jc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [N-1:0] q
);
  localparam logic [N-1:0] HEAD_CODE = {{(N-1){1'b0}}, 1'b1};
  localparam logic [N-1:0] TAIL_CODE = {{(N-1){1'b1}}, 1'b0};

  logic [N-1:0] state;
  logic [N-1:0] next_d;
  jc_op_e       op;

  jc_boundary_detect #(.N(N)) u_detect (
    .state (state),
    .op    (op)
  );

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic sin;
    if (i == 0) begin : g_feedback
      assign sin = ~state[N-1];
    end else begin : g_chain
      assign sin = state[i-1];
    end
    jc_stage #(.IDX(i)) u_stage (
      .op       (op),
      .shift_in (sin),
      .d        (next_d[i])
    );
  end

  jc_state_reg #(.N(N)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (next_d),
    .q     (state)
  );

  assign q = state;

  // R3: low boundary loads the head code
  a_r3_low_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (!q[0] && !q[N-1]) |=> (q == HEAD_CODE));

  // R4: high boundary loads the tail code
  a_r4_high_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (q[0] && q[N-1]) |=> (q == TAIL_CODE));

  // R5: unequal ends shift with inverted feedback
  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (q[0] != q[N-1]) |=> ((q[N-1:1] == $past(q[N-2:0])) && (q[0] == !$past(q[N-1]))));

  // R6: the legal cycle is closed
  a_r6_stay_legal: assert property (@(posedge clk) disable iff (!rst_n)
    jc_is_legal(32'(q), N) |=> jc_is_legal(32'(q), N));

  if (N == 4) begin : g_conv_chk
    // R7: any code is legal within two clocks
    a_r7_converge: assert property (@(posedge clk) disable iff (!rst_n)
      !jc_is_legal(32'(q), N) |-> ##2 jc_is_legal(32'(q), N));
  end
endmodule

// File: tb/tb_jc_selfcorrect_counter.sv
module tb_jc_selfcorrect_counter;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 16;

  // each row {start, after 1 clock, after 2 clocks}, codes written Q0Q1Q2Q3
  localparam logic [11:0] VEC [NROWS] = '{
    {4'b0000, 4'b1000, 4'b1100},
    {4'b1000, 4'b1100, 4'b1110},
    {4'b1100, 4'b1110, 4'b1111},
    {4'b1110, 4'b1111, 4'b0111},
    {4'b1111, 4'b0111, 4'b0011},
    {4'b0111, 4'b0011, 4'b0001},
    {4'b0011, 4'b0001, 4'b0000},
    {4'b0001, 4'b0000, 4'b1000},
    {4'b0010, 4'b1000, 4'b1100},
    {4'b0100, 4'b1000, 4'b1100},
    {4'b0110, 4'b1000, 4'b1100},
    {4'b1001, 4'b0111, 4'b0011},
    {4'b1011, 4'b0111, 4'b0011},
    {4'b1101, 4'b0111, 4'b0011},
    {4'b1010, 4'b1101, 4'b0111},
    {4'b0101, 4'b0010, 4'b1000}
  };

  localparam logic [3:0] CYCLE [8] = '{4'b0000, 4'b1000, 4'b1100, 4'b1110,
                                       4'b1111, 4'b0111, 4'b0011, 4'b0001};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] q;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jc_selfcorrect_counter #(.N(4)) dut (
    .clk   (clk),
    .rst_n (rst_n),
    .q     (q)
  );

  function automatic logic [3:0] to_port(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  task automatic check(input string req, input logic [3:0] exp_q0q3);
    n_chk++;
    if (q !== to_port(exp_q0q3)) begin
      n_bad++;
      $display("FAIL %s: q(Q0Q1Q2Q3)=%b%b%b%b expected %b", req,
               q[0], q[1], q[2], q[3], exp_q0q3);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    tick();
    check("R1 reset", 4'b0000);

    // R2/R3/R4/R5/R6/R7: each of the 16 codes, one and two clocks later
    for (int r = 0; r < NROWS; r++) begin
      rst_n = 1'b0;
      tick();
      force dut.u_reg.state_q = to_port(VEC[r][11:8]);
      #1;
      release dut.u_reg.state_q;
      rst_n = 1'b1;
      tick();
      check(r < 8 ? "R2 step" : "R3/R4/R5 first step", VEC[r][7:4]);
      tick();
      check(r >= 14 ? "R7 two-clock merge" : "R6 second step", VEC[r][3:0]);
    end

    // R2/R6: full cycle from reset, twice round
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    for (int k = 1; k <= 16; k++) begin
      tick();
      check("R2 cycle walk", CYCLE[k % 8]);
    end

    // R1: reset in mid-cycle wins over the shift
    tick();
    tick();
    rst_n = 1'b0;
    tick();
    check("R1 mid-cycle reset", 4'b0000);

    // R1: reset wins over a forced boundary load (state 1001)
    force dut.u_reg.state_q = to_port(4'b1001);
    #1;
    release dut.u_reg.state_q;
    tick();
    check("R1 reset over load", 4'b0000);
    rst_n = 1'b1;
    tick();
    check("R3 load after reset", 4'b1000);

    finish_run();
  end
endmodule